// File: doc/BRIEF.md
# Timeout-Driven Processor Power Manager

This block decides when a processor may stop its clock and when it may shut down completely. It has three stable power states. In RUN the processor is fully active. In IDLE the core is halted but interrupt monitoring stays alive. In SLEEP all on-chip activity is off. Every move between two states takes a fixed number of cycles. The manager models each of these latencies with a down-counter, so the rest of the chip sees exactly when a move starts and when it completes.

The processor reports activity on a busy line. When it drops busy, the manager halts the core. If the core then stays idle for a programmable number of cycles, the manager shuts it down. Only a wake request brings the processor out of SLEEP. At that point the manager compares the time the processor actually spent shut down with a break-even threshold and records a wrong shutdown if the shutdown was too short to pay back its cost. The timeout is either taken straight from an input, or, in adaptive mode, doubled after each wrong shutdown and halved after each correct one, within a programmable window.

Latencies are given in microseconds and converted to cycles with a cycles-per-microsecond parameter.

Top module: `pm_timeout_manager`

## Requirements
- R1: After synchronous reset the manager is in RUN (state code 0) with no transition in progress, and both event counters read zero.
- R2: The state code and power output are RUN = 0 with 400000 uW, IDLE = 1 with 50000 uW, and SLEEP = 2 with 160 uW. While a transition is under way, the transition flag is 1 and the state code and power still show the state being left.
- R3: Transition lengths in cycles, each multiplied by CYC_PER_US, are:
  - RUN to IDLE and IDLE to RUN: LAT_RUN_IDLE_US (default 10).
  - RUN to SLEEP and IDLE to SLEEP: LAT_SHUT_US (default 90).
  - SLEEP to RUN: LAT_WAKE_US (default 160000).
- R4: In RUN with busy low, the manager starts RUN to IDLE. If the effective timeout is 0, it starts RUN to SLEEP instead. In IDLE, a high busy or a wake request starts IDLE to RUN. In RUN with busy high, and in SLEEP with no wake request, the state holds, whatever busy does.
- R5: IDLE that lasts T consecutive cycles with busy low and no wake request starts IDLE to SLEEP, where T is the effective timeout. The shutdown counter increments in the first cycle of every shutdown transition.
- R6: The shutdown length is the number of cycles from the first cycle of a shutdown transition (counted as 0) to the cycle in which a wake request is first sampled. If that length is below the break-even input, the wrong-shutdown counter increments.
- R7: A wake request sampled during a shutdown transition does not shorten it. When the transition completes, SLEEP to RUN starts at once, with no stable SLEEP cycle in between.
- R8: While RUN to IDLE or IDLE to RUN is in progress, busy changes and wake requests neither change its length or destination nor touch the counters.
- R9: With the mode input low, the effective timeout equals the timeout input. With it high, the timeout starts from the last input value clamped to [min, max]. After each wrong shutdown it doubles, and after each correct one it halves, always clamped to [min, max]. The effective timeout is visible on an output.
- R10: Both event counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Processor has work (1) or is idle (0) |
| wake_i | input | 1 | Interrupt or wake request |
| timeout_i | input | TMO_W | Idle timeout in cycles for fixed mode and adaptive seed |
| breakeven_i | input | TMO_W | Break-even shutdown length in cycles |
| adaptive_i | input | 1 | 0 = fixed timeout, 1 = adaptive timeout |
| tmo_min_i | input | TMO_W | Lower clamp for the adaptive timeout |
| tmo_max_i | input | TMO_W | Upper clamp for the adaptive timeout |
| pm_state_o | output | 2 | State code: 0 RUN, 1 IDLE, 2 SLEEP |
| in_transition_o | output | 1 | A state change is in progress |
| power_uw_o | output | 19 | Nominal power of the shown state in microwatts |
| cur_timeout_o | output | TMO_W | Effective idle timeout |
| shutdowns_o | output | CNT_W | Total shutdowns, saturating |
| wrong_shutdowns_o | output | CNT_W | Shutdowns shorter than break-even, saturating |

## Verification
The properties assume that the adaptive clamp window satisfies tmo_min_i ≤ tmo_max_i and stays fixed while adaptive mode is selected, and that every latency parameter gives at least one cycle. The stimulus sets the window once during reset and never changes it. It changes inputs only on falling clock edges and raises the mode input only while the processor is busy in RUN. Wake requests are single-cycle pulses. This keeps the adaptive register seeded from a value already inside the window, and makes every sampled shutdown length exactly computable from the cycle in which the bench drives the pulse.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

    // Controller states: three stable states plus one per directed move
    typedef enum logic [2:0] {
        S_RUN   = 3'd0,
        S_IDLE  = 3'd1,
        S_SLEEP = 3'd2,
        S_R2I   = 3'd3,
        S_I2R   = 3'd4,
        S_R2S   = 3'd5,
        S_I2S   = 3'd6,
        S_S2R   = 3'd7
    } pm_fsm_e;

    // Externally visible state code
    typedef enum logic [1:0] {
        CODE_RUN   = 2'd0,
        CODE_IDLE  = 2'd1,
        CODE_SLEEP = 2'd2
    } pm_code_e;

    // Latency class of a move
    typedef enum logic [1:0] {
        LAT_NONE  = 2'd0,
        LAT_SHORT = 2'd1,
        LAT_SHUT  = 2'd2,
        LAT_WAKE  = 2'd3
    } pm_lat_e;

    // Result of classifying one shutdown
    typedef struct packed {
        logic valid;
        logic wrong;
    } pm_verdict_t;

    localparam int PWR_W = 19;
    localparam logic [PWR_W-1:0] PWR_RUN_UW   = 19'd400000;
    localparam logic [PWR_W-1:0] PWR_IDLE_UW  = 19'd50000;
    localparam logic [PWR_W-1:0] PWR_SLEEP_UW = 19'd160;

    // State shown outside: a move reports the state it leaves
    function automatic pm_code_e code_of(pm_fsm_e s);
        case (s)
            S_RUN, S_R2I, S_R2S: return CODE_RUN;
            S_IDLE, S_I2R, S_I2S: return CODE_IDLE;
            default:             return CODE_SLEEP;
        endcase
    endfunction

    function automatic logic is_moving(pm_fsm_e s);
        return (s == S_R2I) || (s == S_I2R) || (s == S_R2S) ||
               (s == S_I2S) || (s == S_S2R);
    endfunction

    // States in which the shutdown length is accumulated
    function automatic logic in_shutdown_phase(pm_fsm_e s);
        return (s == S_R2S) || (s == S_I2S) || (s == S_SLEEP);
    endfunction

    function automatic pm_lat_e lat_class_of(pm_fsm_e s);
        case (s)
            S_R2I, S_I2R: return LAT_SHORT;
            S_R2S, S_I2S: return LAT_SHUT;
            S_S2R:        return LAT_WAKE;
            default:      return LAT_NONE;
        endcase
    endfunction

    function automatic logic [PWR_W-1:0] power_of(pm_code_e c);
        case (c)
            CODE_RUN:  return PWR_RUN_UW;
            CODE_IDLE: return PWR_IDLE_UW;
            default:   return PWR_SLEEP_UW;
        endcase
    endfunction

endpackage

// File: rtl/pm_latency_timer.sv
`timescale 1ns/1ps
module pm_latency_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] load_i,
    output logic         done_o
);

    logic [W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (start_i) begin
            remain_q <= load_i;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - W'(1);
        end
    end

    // A move loaded with L-1 lasts exactly L cycles
    assign done_o = (remain_q == '0);

endmodule

// File: rtl/pm_timeout_adapt.sv
`timescale 1ns/1ps
module pm_timeout_adapt
    import pm_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adaptive_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic [TMO_W-1:0] tmo_min_i,
    input  logic [TMO_W-1:0] tmo_max_i,
    input  pm_verdict_t      verdict_i,
    output logic [TMO_W-1:0] eff_tmo_o
);

    logic [TMO_W-1:0] adapt_q;
    logic [TMO_W-1:0] adapt_d;
    logic [TMO_W:0]   doubled;
    logic [TMO_W-1:0] grown;
    logic [TMO_W-1:0] shrunk;
    logic [TMO_W-1:0] seed;

    always_comb begin
        // Seed: input value pulled into the window
        if (timeout_i < tmo_min_i) begin
            seed = tmo_min_i;
        end else if (timeout_i > tmo_max_i) begin
            seed = tmo_max_i;
        end else begin
            seed = timeout_i;
        end

        // Growth after a wrong shutdown, limited by the upper bound
        doubled = {adapt_q, 1'b0};
        if (doubled > {1'b0, tmo_max_i}) begin
            grown = tmo_max_i;
        end else if (doubled[TMO_W-1:0] < tmo_min_i) begin
            grown = tmo_min_i;
        end else begin
            grown = doubled[TMO_W-1:0];
        end

        // Shrink after a correct shutdown, limited by the lower bound
        if ((adapt_q >> 1) < tmo_min_i) begin
            shrunk = tmo_min_i;
        end else if ((adapt_q >> 1) > tmo_max_i) begin
            shrunk = tmo_max_i;
        end else begin
            shrunk = adapt_q >> 1;
        end

        adapt_d = adapt_q;
        if (!adaptive_i) begin
            adapt_d = seed;
        end else if (verdict_i.valid) begin
            adapt_d = verdict_i.wrong ? grown : shrunk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adapt_q <= '0;
        end else begin
            adapt_q <= adapt_d;
        end
    end

    assign eff_tmo_o = adaptive_i ? adapt_q : timeout_i;

endmodule

// File: rtl/pm_event_counters.sv
`timescale 1ns/1ps
module pm_event_counters #(
    parameter int N = 2,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        bump_i,
    output logic [N-1:0][W-1:0] count_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cnt
            logic [W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (bump_i[g] && (cnt_q != '1)) begin
                    cnt_q <= cnt_q + W'(1);
                end
            end
            assign count_o[g] = cnt_q;
        end
    endgenerate

endmodule

// File: rtl/pm_timeout_manager.sv
`timescale 1ns/1ps
module pm_timeout_manager
    import pm_pkg::*;
#(
    parameter int CYC_PER_US      = 8,
    parameter int LAT_RUN_IDLE_US = 10,
    parameter int LAT_SHUT_US     = 90,
    parameter int LAT_WAKE_US     = 160000,
    parameter int TMO_W           = 16,
    parameter int CNT_W           = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             wake_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic [TMO_W-1:0] breakeven_i,
    input  logic             adaptive_i,
    input  logic [TMO_W-1:0] tmo_min_i,
    input  logic [TMO_W-1:0] tmo_max_i,
    output logic [1:0]       pm_state_o,
    output logic             in_transition_o,
    output logic [18:0]      power_uw_o,
    output logic [TMO_W-1:0] cur_timeout_o,
    output logic [CNT_W-1:0] shutdowns_o,
    output logic [CNT_W-1:0] wrong_shutdowns_o
);

    localparam int SHORT_CYC = LAT_RUN_IDLE_US * CYC_PER_US;
    localparam int SHUT_CYC  = LAT_SHUT_US * CYC_PER_US;
    localparam int WAKE_CYC  = LAT_WAKE_US * CYC_PER_US;
    localparam int MAX_AB    = (SHORT_CYC > SHUT_CYC) ? SHORT_CYC : SHUT_CYC;
    localparam int MAX_CYC   = (MAX_AB > WAKE_CYC) ? MAX_AB : WAKE_CYC;
    localparam int LAT_W     = $clog2(MAX_CYC + 1);
    localparam logic [LAT_W-1:0] LOAD_SHORT = LAT_W'(SHORT_CYC - 1);
    localparam logic [LAT_W-1:0] LOAD_SHUT  = LAT_W'(SHUT_CYC - 1);
    localparam logic [LAT_W-1:0] LOAD_WAKE  = LAT_W'(WAKE_CYC - 1);

    pm_fsm_e          st_q, st_d;
    logic [TMO_W-1:0] idle_cnt_q;
    logic [TMO_W-1:0] sd_len_q;
    logic             wake_seen_q;
    logic             sd_start;
    logic             lat_start;
    logic [LAT_W-1:0] lat_load;
    logic             lat_done;
    pm_verdict_t      verdict;
    logic [TMO_W-1:0] eff_tmo;
    logic             idle_expired;
    logic [1:0][CNT_W-1:0] counts;

    assign idle_expired = ((TMO_W+1)'(idle_cnt_q) + (TMO_W+1)'(1)) >= (TMO_W+1)'(eff_tmo);

    // Next-state decision
    always_comb begin
        st_d          = st_q;
        sd_start      = 1'b0;
        verdict.valid = 1'b0;
        verdict.wrong = (sd_len_q < breakeven_i);
        case (st_q)
            S_RUN: begin
                if (!busy_i) begin
                    if (eff_tmo == '0) begin
                        st_d     = S_R2S;
                        sd_start = 1'b1;
                    end else begin
                        st_d = S_R2I;
                    end
                end
            end
            S_IDLE: begin
                if (busy_i || wake_i) begin
                    st_d = S_I2R;
                end else if (idle_expired) begin
                    st_d     = S_I2S;
                    sd_start = 1'b1;
                end
            end
            S_SLEEP: begin
                if (wake_i) begin
                    verdict.valid = 1'b1;
                    st_d          = S_S2R;
                end
            end
            S_R2S, S_I2S: begin
                if (wake_i && !wake_seen_q) begin
                    verdict.valid = 1'b1;
                end
                if (lat_done) begin
                    st_d = (wake_seen_q || wake_i) ? S_S2R : S_SLEEP;
                end
            end
            S_R2I: if (lat_done) st_d = S_IDLE;
            S_I2R: if (lat_done) st_d = S_RUN;
            S_S2R: if (lat_done) st_d = S_RUN;
            default: st_d = S_RUN;
        endcase
    end

    // Latency selection for a newly started move
    always_comb begin
        lat_start = is_moving(st_d) && (st_d != st_q);
        case (lat_class_of(st_d))
            LAT_SHORT: lat_load = LOAD_SHORT;
            LAT_SHUT:  lat_load = LOAD_SHUT;
            LAT_WAKE:  lat_load = LOAD_WAKE;
            default:   lat_load = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_RUN;
            idle_cnt_q  <= '0;
            sd_len_q    <= '0;
            wake_seen_q <= 1'b0;
        end else begin
            st_q <= st_d;

            if ((st_d == S_IDLE) && (st_q != S_IDLE)) begin
                idle_cnt_q <= '0;
            end else if ((st_q == S_IDLE) && (st_d == S_IDLE) && (idle_cnt_q != '1)) begin
                idle_cnt_q <= idle_cnt_q + TMO_W'(1);
            end

            if (sd_start) begin
                sd_len_q <= '0;
            end else if (in_shutdown_phase(st_q) && (sd_len_q != '1)) begin
                sd_len_q <= sd_len_q + TMO_W'(1);
            end

            if (sd_start) begin
                wake_seen_q <= 1'b0;
            end else if (verdict.valid) begin
                wake_seen_q <= 1'b1;
            end
        end
    end

    pm_latency_timer #(
        .W (LAT_W)
    ) u_lat (
        .clk     (clk),
        .rst     (rst),
        .start_i (lat_start),
        .load_i  (lat_load),
        .done_o  (lat_done)
    );

    pm_timeout_adapt #(
        .TMO_W (TMO_W)
    ) u_tmo (
        .clk        (clk),
        .rst        (rst),
        .adaptive_i (adaptive_i),
        .timeout_i  (timeout_i),
        .tmo_min_i  (tmo_min_i),
        .tmo_max_i  (tmo_max_i),
        .verdict_i  (verdict),
        .eff_tmo_o  (eff_tmo)
    );

    pm_event_counters #(
        .N (2),
        .W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .bump_i  ({verdict.valid && verdict.wrong, sd_start}),
        .count_o (counts)
    );

    assign pm_state_o        = code_of(st_q);
    assign in_transition_o   = is_moving(st_q);
    assign power_uw_o        = power_of(code_of(st_q));
    assign cur_timeout_o     = eff_tmo;
    assign shutdowns_o       = counts[0];
    assign wrong_shutdowns_o = counts[1];

endmodule

// File: rtl/pm_timeout_manager_chk.sv
`timescale 1ns/1ps
module pm_timeout_manager_chk #(
    parameter int TMO_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_i,
    input logic             wake_i,
    input logic             adaptive_i,
    input logic [TMO_W-1:0] tmo_min_i,
    input logic [TMO_W-1:0] tmo_max_i,
    input logic [1:0]       pm_state_o,
    input logic             in_transition_o,
    input logic [TMO_W-1:0] cur_timeout_o,
    input logic [CNT_W-1:0] shutdowns_o,
    input logic [CNT_W-1:0] wrong_shutdowns_o
);

    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        pm_state_o != 2'd3);

    p_source_shown_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_transition_o) |-> $stable(pm_state_o));

    p_wake_ends_run_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_transition_o) && ($past(pm_state_o) == 2'd2)) |-> (pm_state_o == 2'd0));

    p_sleep_holds_r4: assert property (@(posedge clk) disable iff (rst)
        ((pm_state_o == 2'd2) && !in_transition_o && !wake_i)
        |=> ((pm_state_o == 2'd2) && !in_transition_o));

    p_idle_leaves_r4: assert property (@(posedge clk) disable iff (rst)
        ((pm_state_o == 2'd1) && !in_transition_o && (busy_i || wake_i))
        |=> (in_transition_o && (pm_state_o == 2'd1)));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (shutdowns_o != $past(shutdowns_o)) |-> (shutdowns_o == $past(shutdowns_o) + CNT_W'(1)));

    p_wrong_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        wrong_shutdowns_o <= shutdowns_o);

    p_tmo_window_r9: assert property (@(posedge clk) disable iff (rst)
        (adaptive_i && $past(adaptive_i))
        |-> ((cur_timeout_o >= tmo_min_i) && (cur_timeout_o <= tmo_max_i)));

endmodule

bind pm_timeout_manager pm_timeout_manager_chk #(
    .TMO_W (TMO_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .busy_i            (busy_i),
    .wake_i            (wake_i),
    .adaptive_i        (adaptive_i),
    .tmo_min_i         (tmo_min_i),
    .tmo_max_i         (tmo_max_i),
    .pm_state_o        (pm_state_o),
    .in_transition_o   (in_transition_o),
    .cur_timeout_o     (cur_timeout_o),
    .shutdowns_o       (shutdowns_o),
    .wrong_shutdowns_o (wrong_shutdowns_o)
);

// File: tb/pm_timeout_manager_test.sv
`timescale 1ns/1ps
module pm_timeout_manager_test;

    localparam int TMO_W = 16;
    localparam int CNT_W = 3;
    localparam int MAXC  = (1 << CNT_W) - 1;
    localparam int L_SH  = 10;
    localparam int L_SD  = 90;
    localparam int L_WK  = 200;
    localparam int BE    = 150;
    localparam int TMIN  = 4;
    localparam int TMAX  = 64;

    logic             clk = 1'b0;
    logic             rst;
    logic             busy, wake, adaptive;
    logic [TMO_W-1:0] timeout, breakeven, tmo_min, tmo_max;
    logic [1:0]       pm_state_o;
    logic             in_transition_o;
    logic [18:0]      power_uw_o;
    logic [TMO_W-1:0] cur_timeout_o;
    logic [CNT_W-1:0] shutdowns_o, wrong_shutdowns_o;

    always #4 clk = ~clk;

    pm_timeout_manager #(
        .CYC_PER_US (1), .LAT_RUN_IDLE_US (L_SH), .LAT_SHUT_US (L_SD),
        .LAT_WAKE_US (L_WK), .TMO_W (TMO_W), .CNT_W (CNT_W)
    ) uut (
        .clk (clk), .rst (rst), .busy_i (busy), .wake_i (wake),
        .timeout_i (timeout), .breakeven_i (breakeven), .adaptive_i (adaptive),
        .tmo_min_i (tmo_min), .tmo_max_i (tmo_max),
        .pm_state_o (pm_state_o), .in_transition_o (in_transition_o),
        .power_uw_o (power_uw_o), .cur_timeout_o (cur_timeout_o),
        .shutdowns_o (shutdowns_o), .wrong_shutdowns_o (wrong_shutdowns_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { int sd; int wr; int tmo; } exp_t;
    exp_t sb[$];
    exp_t mon_e;

    // Reference model state
    int  m_sd = 0, m_wr = 0, m_tmo = 20;
    bit  m_adapt = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    // Driver side of the scoreboard: predicts the result of one wake
    task automatic note_wake(input int len);
        bit wrong;
        wrong = (len < BE);
        if (wrong) m_wr = sat_inc(m_wr);
        if (m_adapt) begin
            if (wrong) m_tmo = (2 * m_tmo > TMAX) ? TMAX : 2 * m_tmo;
            else       m_tmo = (m_tmo / 2 < TMIN) ? TMIN : m_tmo / 2;
        end
        sb.push_back('{m_sd, m_wr, m_tmo});
    endtask

    // Monitor: compares at the first cycle of every wakeup move (R6, R9, R10)
    logic s2r_now, s2r_prev = 1'b0;
    always @(negedge clk) begin
        s2r_now = !rst && in_transition_o && (pm_state_o == 2'd2);
        if (s2r_now && !s2r_prev) begin
            if (sb.size() == 0) begin
                chk("R6", "unexpected wakeup (queue size)", 0, 1);
            end else begin
                mon_e = sb.pop_front();
                chk("R5", "shutdowns at wakeup", int'(shutdowns_o), mon_e.sd);
                chk("R6", "wrong shutdowns at wakeup", int'(wrong_shutdowns_o), mon_e.wr);
                chk("R9", "timeout at wakeup", int'(cur_timeout_o), mon_e.tmo);
            end
        end
        s2r_prev = s2r_now;
    end

    task automatic span(input logic [1:0] st, input logic tr, output int n);
        n = 0;
        while ((pm_state_o == st) && (in_transition_o == tr) && !done) begin
            n++;
            @(negedge clk);
        end
    endtask

    // One full idle -> shutdown -> wake cycle; wake d cycles after SLEEP is shown
    task automatic round(input int d);
        int n;
        busy = 1'b0;
        @(negedge clk);
        chk("R4", "run-to-idle started", int'(in_transition_o), 1);
        chk("R2", "source state shown", int'(pm_state_o), 0);
        span(2'd0, 1'b1, n);
        chk("R3", "run-to-idle cycles", n, L_SH);
        chk("R2", "idle power", int'(power_uw_o), 50000);
        span(2'd1, 1'b0, n);
        chk("R5", "idle cycles before shutdown", n, m_tmo);
        m_sd = sat_inc(m_sd);
        chk("R10", "shutdown count", int'(shutdowns_o), m_sd);
        span(2'd1, 1'b1, n);
        chk("R3", "idle-to-sleep cycles", n, L_SD);
        chk("R2", "sleep code", int'(pm_state_o), 2);
        chk("R2", "sleep power", int'(power_uw_o), 160);
        repeat (d) @(negedge clk);
        wake = 1'b1;
        busy = 1'b1;
        note_wake(L_SD + d);
        @(negedge clk);
        wake = 1'b0;
        span(2'd2, 1'b1, n);
        chk("R3", "wakeup cycles", n, L_WK);
        chk("R2", "run power after wake", int'(power_uw_o), 400000);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog: actual hung run, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; busy = 1'b1; wake = 1'b0; adaptive = 1'b0;
        timeout = 20; breakeven = BE; tmo_min = TMIN; tmo_max = TMAX;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "state after reset", int'(pm_state_o), 0);
        chk("R1", "transition flag after reset", int'(in_transition_o), 0);
        chk("R1", "shutdowns after reset", int'(shutdowns_o), 0);
        chk("R1", "wrong after reset", int'(wrong_shutdowns_o), 0);
        chk("R2", "run power", int'(power_uw_o), 400000);
        chk("R9", "fixed timeout follows input", int'(cur_timeout_o), 20);

        // Fixed mode: one wrong and one correct shutdown (R6)
        round(10);
        round(80);

        // R7 wake during idle-to-sleep
        busy = 1'b0;
        @(negedge clk);
        span(2'd0, 1'b1, n);
        span(2'd1, 1'b0, n);
        m_sd = sat_inc(m_sd);
        chk("R5", "shutdown count at pending wake", int'(shutdowns_o), m_sd);
        wake = 1'b1; busy = 1'b1;
        note_wake(0);
        @(negedge clk);
        wake = 1'b0;
        span(2'd1, 1'b1, n);
        chk("R7", "shutdown move not shortened", n + 1, L_SD);
        chk("R7", "wakeup starts at once (state)", int'(pm_state_o), 2);
        chk("R7", "wakeup starts at once (flag)", int'(in_transition_o), 1);
        span(2'd2, 1'b1, n);
        chk("R7", "wakeup cycles after pending wake", n, L_WK);

        // R8 busy and wake ignored during short moves
        busy = 1'b0;
        @(negedge clk);
        busy = 1'b1; wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        @(negedge clk);
        busy = 1'b0;
        span(2'd0, 1'b1, n);
        chk("R8", "run-to-idle length with busy glitch", n + 2, L_SH);
        chk("R8", "destination still idle", int'(pm_state_o), 1);
        busy = 1'b1;
        @(negedge clk);
        chk("R4", "busy in idle starts idle-to-run", int'(in_transition_o), 1);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        span(2'd1, 1'b1, n);
        chk("R8", "idle-to-run length with wake pulse", n + 1, L_SH);
        chk("R8", "back in run", int'(pm_state_o), 0);
        chk("R8", "wrong count untouched", int'(wrong_shutdowns_o), m_wr);
        chk("R8", "shutdown count untouched", int'(shutdowns_o), m_sd);
        repeat (5) @(negedge clk);
        chk("R4", "busy run holds", int'(in_transition_o), 0);

        // R4 zero timeout: direct shutdown, sleep ignores busy
        timeout = 0; m_tmo = 0;
        @(negedge clk);
        chk("R9", "fixed timeout zero shown", int'(cur_timeout_o), 0);
        busy = 1'b0;
        @(negedge clk);
        m_sd = sat_inc(m_sd);
        chk("R4", "run-to-sleep started", int'(in_transition_o), 1);
        chk("R4", "direct shutdown counted", int'(shutdowns_o), m_sd);
        span(2'd0, 1'b1, n);
        chk("R3", "run-to-sleep cycles", n, L_SD);
        busy = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4", "sleep ignores busy (state)", int'(pm_state_o), 2);
        chk("R4", "sleep ignores busy (flag)", int'(in_transition_o), 0);
        wake = 1'b1;
        note_wake(L_SD + 5);
        @(negedge clk);
        wake = 1'b0;
        span(2'd2, 1'b1, n);
        chk("R3", "wakeup after direct shutdown", n, L_WK);

        // R9 adaptive mode
        timeout = 20; m_tmo = 20;
        @(negedge clk);
        adaptive = 1'b1; m_adapt = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", "adaptive seed", int'(cur_timeout_o), 20);
        round(100);     // correct -> 10
        round(100);     // correct -> 5
        round(100);     // correct -> clamp 4
        chk("R9", "lower clamp", int'(cur_timeout_o), TMIN);
        round(0);       // wrong -> 8
        round(0);       // 16
        round(0);       // 32
        round(0);       // 64
        round(0);       // clamp 64
        chk("R9", "upper clamp", int'(cur_timeout_o), TMAX);
        chk("R10", "shutdowns saturate", int'(shutdowns_o), MAXC);
        chk("R10", "wrong saturates", int'(wrong_shutdowns_o), MAXC);
        chk("R6", "scoreboard drained", sb.size(), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule